// File: doc/BRIEF.md
# SPI FIFO and Interrupt Front-End

This block is the register-facing half of an SPI master. A processor reaches it through a plain select/write/address register port. Writes to the data address queue words for transmission. Reads from the same address pop received words. The serial engine sits on the other side and exchanges words with the block over two valid/ready streams: transmit words leave the block and received words enter it.

Each direction has an 8-word FIFO with a programmable threshold and a flush control. The block compares FIFO occupancy against the thresholds to raise transfer-request levels. It latches three events: a received word arriving while the receive FIFO is full, the engine finishing with enough receive data queued, and the engine finishing with the transmit queue drained. A single interrupt line is the OR of the events that are enabled.

Software turns the engine on and off with a global enable. Clearing the enable stops both streams at once.

Top module: `spi_fifo_irq_front`

## Requirements
- R1: After reset, the control, interrupt-enable and FIFO-control registers read 0, both FIFOs are empty, `tx_valid`, `rx_ready` and `irq` are low, and the interrupt register at 0x1C reads 0x004 (only the transmit-room level is set).
- R2: Bit 0 of the control register (0x00) is the enable and drives `eng_en`. While it is 0, `tx_valid` and `rx_ready` stay low, so no word moves on either stream.
- R3: Writes to 0x24 enter the 8-deep transmit FIFO, and the words leave on `tx_data` in write order. A write while the FIFO is full is dropped.
- R4: Received words are accepted while the enable is set and the receive FIFO is not full. Reads of 0x24 return them in arrival order, and a read of an empty FIFO returns 0. In the status register (0x14), bit 0 is set while the receive FIFO is not empty and bit 7 mirrors `eng_busy`.
- R5: The FIFO-control register (0x20) holds the transmit threshold in bits 11:8 and the receive threshold in bits 3:0, and both read back. Writing 1 to bit 12 empties the transmit FIFO and writing 1 to bit 4 empties the receive FIFO, both effective the next cycle. Bits 12 and 4 read as 0.
- R6: Interrupt register bit 9 (receive threshold reached) and bit 1 (receive transfer request) are set while the receive FIFO holds at least one word and at least the receive-threshold number of words.
- R7: Interrupt register bit 2 (transmit transfer request) is set while the transmit FIFO holds no more words than the transmit threshold.
- R8: A word offered on the receive stream while the enable is set and the receive FIFO is full is dropped, and the overrun event (bit 0 of 0x1C) latches until it is cleared.
- R9: When `eng_busy` falls, bit 3 (receive complete) latches if the receive-threshold flag is set, and bit 4 (transmit complete) latches if the transmit FIFO is empty.
- R10: Writing 0x1C with ones in bits 4, 3 or 0 clears the matching latched events. A new event in the same cycle as its clear wins.
- R11: The interrupt-enable register (0x18) uses bits 4:0 and reads back. `irq` is high exactly when some bit of 0x1C[4:0] and the same bit of the enable register are both set.
- R12: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| eng_en | output | 1 | Enable to the serial engine |
| eng_busy | input | 1 | Serial engine is shifting |
| tx_valid | output | 1 | Transmit word available |
| tx_ready | input | 1 | Engine takes the transmit word |
| tx_data | output | DATA_W | Transmit word |
| rx_valid | input | 1 | Engine offers a received word |
| rx_ready | output | 1 | Block accepts the received word |
| rx_data | input | DATA_W | Received word |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks the receive threshold comparison across its edges: a zero threshold with zero and with one word, one word short of the threshold, exactly at it, and a full FIFO at threshold 8. A comparator with an off-by-one or a missing empty guard flips the flag in one of these rows. The bench also fills each FIFO to depth and pushes one more word. A design with a wrong full test would either drop the eighth word or corrupt the oldest, and a design with broken overrun logic would not latch the overrun bit. Completion events are produced with a busy pulse both with enough receive data queued and with too little. This exposes logic that latches receive-complete without looking at the threshold flag. Finally, the interrupt line is toggled through the enable mask and the write-one clear, which catches a clear that acts on the wrong bit or an output that ignores the mask.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int REG_W = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTL  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IE   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_IRQ  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_FCTL = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_DATA = 6'h24;

    // event / level positions in the interrupt register
    localparam int EV_OVR   = 0;
    localparam int EV_RXREQ = 1;
    localparam int EV_TXREQ = 2;
    localparam int EV_RC    = 3;
    localparam int EV_TC    = 4;
    localparam int EV_RXTHR = 9;
    localparam int EV_N     = 5;

    localparam int FC_TXFL  = 12;
    localparam int FC_RXFL  = 4;
    localparam int THR_W    = 4;

    localparam int ST_RNE   = 0;
    localparam int ST_BUSY  = 7;

    typedef struct packed {
        logic             en;
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic [EV_N-1:0]  ie;
    } regs_t;
endpackage

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } st_t;

    st_t st_d, st_q;
    logic do_push, do_pop;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = st_q.mem[st_q.rp];
    assign count   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sfe_irq.sv
module sfe_irq
    import sfe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eng_busy,
    input  logic            tx_empty,
    input  logic            rx_reached,
    input  logic            tx_room,
    input  logic            ovr_evt,
    input  logic            clr_we,
    input  logic [EV_N-1:0] clr_bits,
    input  logic [EV_N-1:0] ie,
    output logic [EV_N-1:0] stat,
    output logic            irq
);
    typedef struct packed {
        logic busy;
        logic tc;
        logic rc;
        logic ovr;
    } ev_t;

    ev_t ev_d, ev_q;
    logic busy_fall;
    logic [EV_N-1:0] clr;

    assign busy_fall = ev_q.busy && !eng_busy;
    assign clr       = clr_we ? clr_bits : '0;

    always_comb begin
        ev_d      = ev_q;
        ev_d.busy = eng_busy;
        ev_d.tc   = (ev_q.tc  && !clr[EV_TC])  || (busy_fall && tx_empty);
        ev_d.rc   = (ev_q.rc  && !clr[EV_RC])  || (busy_fall && rx_reached);
        ev_d.ovr  = (ev_q.ovr && !clr[EV_OVR]) || ovr_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    always_comb begin
        stat           = '0;
        stat[EV_TC]    = ev_q.tc;
        stat[EV_RC]    = ev_q.rc;
        stat[EV_TXREQ] = tx_room;
        stat[EV_RXREQ] = rx_reached;
        stat[EV_OVR]   = ev_q.ovr;
    end

    assign irq = |(stat & ie);
endmodule

// File: rtl/spi_fifo_irq_front.sv
module spi_fifo_irq_front
    import sfe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              eng_en,
    input  logic              eng_busy,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data
    ,output logic             irq
);
    localparam int CW = $clog2(DEPTH+1);

    regs_t regs_d, regs_q;

    logic wr, rd;
    logic tx_flush, rx_flush, tx_push, tx_pop, rx_push, rx_pop;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [DATA_W-1:0] rx_head;
    logic rx_reached, tx_room, ovr_evt;
    logic [EV_N-1:0] stat_w;
    logic [EV_N-1:0] ie_w;
    logic unused_wbits;

    assign wr = reg_sel && reg_we;
    assign rd = reg_sel && !reg_we;
    assign unused_wbits = ^{reg_wdata[31:13], reg_wdata[7:5]};

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (reg_addr)
                OFS_CTL:  regs_d.en = reg_wdata[0];
                OFS_IE:   regs_d.ie = reg_wdata[EV_N-1:0];
                OFS_FCTL: begin
                    regs_d.tx_thr = reg_wdata[8 +: THR_W];
                    regs_d.rx_thr = reg_wdata[0 +: THR_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign tx_flush = wr && (reg_addr == OFS_FCTL) && reg_wdata[FC_TXFL];
    assign rx_flush = wr && (reg_addr == OFS_FCTL) && reg_wdata[FC_RXFL];
    assign tx_push  = wr && (reg_addr == OFS_DATA);
    assign rx_pop   = rd && (reg_addr == OFS_DATA);
    assign tx_valid = regs_q.en && !tx_empty;
    assign rx_ready = regs_q.en && !rx_full;
    assign tx_pop   = tx_valid && tx_ready;
    assign rx_push  = rx_valid && rx_ready;
    assign ovr_evt  = regs_q.en && rx_valid && rx_full;
    assign eng_en   = regs_q.en;
    assign ie_w     = regs_q.ie;

    sfe_fifo #(.W(DATA_W), .DEPTH(DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .wdata(reg_wdata[DATA_W-1:0]),
        .pop(tx_pop), .rdata(tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    sfe_fifo #(.W(DATA_W), .DEPTH(DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .wdata(rx_data),
        .pop(rx_pop), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    logic unused_txfull;
    assign unused_txfull = tx_full;

    assign rx_reached = !rx_empty && (int'(rx_cnt) >= int'(regs_q.rx_thr));
    assign tx_room    = int'(tx_cnt) <= int'(regs_q.tx_thr);

    sfe_irq irq_i (
        .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy),
        .tx_empty(tx_empty), .rx_reached(rx_reached), .tx_room(tx_room),
        .ovr_evt(ovr_evt),
        .clr_we(wr && (reg_addr == OFS_IRQ)),
        .clr_bits(reg_wdata[EV_N-1:0]),
        .ie(regs_q.ie), .stat(stat_w), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (rd) begin
            case (reg_addr)
                OFS_CTL:  reg_rdata[0] = regs_q.en;
                OFS_STAT: begin
                    reg_rdata[ST_RNE]  = !rx_empty;
                    reg_rdata[ST_BUSY] = eng_busy;
                end
                OFS_IE:   reg_rdata[EV_N-1:0] = regs_q.ie;
                OFS_IRQ:  begin
                    reg_rdata[EV_N-1:0] = stat_w;
                    reg_rdata[EV_RXTHR] = rx_reached;
                end
                OFS_FCTL: begin
                    reg_rdata[8 +: THR_W] = regs_q.tx_thr;
                    reg_rdata[0 +: THR_W] = regs_q.rx_thr;
                end
                OFS_DATA: if (!rx_empty) reg_rdata = REG_W'(rx_head);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sfe_chk.sv
module sfe_chk
    import sfe_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_sel,
    input logic                       reg_we,
    input logic [5:0]                 reg_addr,
    input logic [4:0]                 wlo,
    input logic                       eng_en,
    input logic                       tx_valid,
    input logic                       rx_ready,
    input logic                       irq,
    input logic [4:0]                 ie,
    input logic [4:0]                 stat,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       rx_reached
);
    logic unused_mid;
    assign unused_mid = ^wlo[3:1];

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_en |-> (!tx_valid && !rx_ready));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_cnt) <= DEPTH);

    p_rxflush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_we && reg_addr == OFS_FCTL && wlo[4]) |=> (rx_cnt == '0));

    p_flag_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) |-> !rx_reached);

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[EV_OVR] && !(reg_sel && reg_we && reg_addr == OFS_IRQ && wlo[0]))
        |=> stat[EV_OVR]);

    p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ie != '0));
endmodule

bind spi_fifo_irq_front sfe_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .wlo(reg_wdata[4:0]), .eng_en(eng_en),
    .tx_valid(tx_valid), .rx_ready(rx_ready), .irq(irq), .ie(ie_w),
    .stat(stat_w), .rx_cnt(rx_cnt), .rx_reached(rx_reached)
);

// File: tb/spi_fifo_irq_front_tb_top.sv
module spi_fifo_irq_front_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_sel = 0, reg_we = 0;
    logic [5:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic eng_en, eng_busy = 0;
    logic tx_valid, tx_ready = 0;
    logic [31:0] tx_data;
    logic rx_valid = 0, rx_ready;
    logic [31:0] rx_data = '0;
    logic irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi_fifo_irq_front dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_en(eng_en), .eng_busy(eng_busy), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
    );

    // entry: {words pushed, rx threshold, expected flag}
    localparam logic [8:0] VEC [8] = '{
        {4'd0, 4'd0, 1'b0}, {4'd1, 4'd0, 1'b1}, {4'd1, 4'd1, 1'b1},
        {4'd2, 4'd3, 1'b0}, {4'd3, 4'd3, 1'b1}, {4'd8, 4'd8, 1'b1},
        {4'd7, 4'd8, 1'b0}, {4'd5, 4'd2, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_sel = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_sel = 1; reg_we = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_sel = 0;
    endtask

    task automatic rx_push(input logic [31:0] d);
        rx_valid = 1; rx_data = d;
        @(posedge clk); @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic tx_pull();
        tx_ready = 1;
        @(posedge clk); @(negedge clk);
        tx_ready = 0;
    endtask

    task automatic busy_pulse();
        eng_busy = 1;
        @(negedge clk);
        eng_busy = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(6'h00, v); check("R1 ctl", v, 0);
        rd(6'h18, v); check("R1 ie", v, 0);
        rd(6'h20, v); check("R1 fctl", v, 0);
        rd(6'h14, v); check("R1 stat", v, 0);
        rd(6'h1C, v); check("R1 irqreg", v, 32'h4);
        check("R1 pins", {tx_valid, rx_ready, irq}, 0);

        // R2 enable gating
        wr(6'h24, 32'h55);
        check("R2 tx_valid while disabled", tx_valid, 0);
        rx_push(32'h77);
        rd(6'h14, v); check("R2 rx ignored while disabled", v, 0);
        wr(6'h00, 1);
        rd(6'h00, v); check("R2 ctl readback", v, 1);
        check("R2 tx_valid after enable", {tx_valid, tx_data}, {1'b1, 32'h55});

        // R5 flush and threshold readback
        wr(6'h20, 32'h1000);
        check("R5 tx flush", tx_valid, 0);
        wr(6'h20, 32'h1315);
        rd(6'h20, v); check("R5 fctl readback, flush bits 0", v, 32'h305);

        // R3 tx order and overflow drop
        wr(6'h20, 32'h1010);
        for (int i = 0; i < 9; i++) wr(6'h24, 32'h100 + i);
        for (int i = 0; i < 8; i++) begin
            check("R3 tx order", {tx_valid, tx_data}, {1'b1, 32'h100 + 32'(i)});
            tx_pull();
        end
        check("R3 ninth word dropped", tx_valid, 0);

        // R4 rx order, empty read, status
        for (int i = 0; i < 3; i++) rx_push(32'hA0 + i);
        rd(6'h14, v); check("R4 rne", v, 32'h1);
        eng_busy = 1;
        rd(6'h14, v); check("R4 busy bit", v, 32'h81);
        eng_busy = 0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            rd(6'h24, v); check("R4 rx order", v, 32'hA0 + 32'(i));
        end
        rd(6'h24, v); check("R4 empty read", v, 0);
        rd(6'h14, v); check("R4 rne clear", v, 0);

        // R6 threshold table
        for (int k = 0; k < 8; k++) begin
            wr(6'h20, 32'h1010 | 32'(VEC[k][4:1]));
            for (int j = 0; j < int'(VEC[k][8:5]); j++) rx_push(32'h200 + j);
            rd(6'h1C, v);
            check("R6 rx threshold flag", v[9], VEC[k][0]);
            check("R6 rx request", v[1], VEC[k][0]);
        end

        // R8 overrun
        wr(6'h20, 32'h1010);
        for (int i = 0; i < 8; i++) rx_push(32'hC0 + i);
        rd(6'h1C, v); check("R8 no overrun at full", v[0], 0);
        rx_push(32'hFF);
        rd(6'h1C, v); check("R8 overrun latched", v[0], 1);
        for (int i = 0; i < 8; i++) begin
            rd(6'h24, v); check("R8 contents kept", v, 32'hC0 + 32'(i));
        end
        rd(6'h14, v); check("R8 extra word dropped", v, 0);

        // R10 write-one clear
        wr(6'h1C, 32'h19);
        rd(6'h1C, v); check("R10 clear", v & 32'h19, 0);

        // R9 completion events
        wr(6'h20, 32'h1012);
        rx_push(32'h1); rx_push(32'h2);
        busy_pulse();
        rd(6'h1C, v); check("R9 rc and tc", v & 32'h18, 32'h18);
        wr(6'h1C, 32'h18);
        rd(6'h1C, v); check("R10 clear rc tc", v & 32'h18, 0);
        wr(6'h20, 32'h0003);
        busy_pulse();
        rd(6'h1C, v); check("R9 rc needs threshold", v & 32'h18, 32'h10);

        // R11 interrupt masking
        check("R11 masked", irq, 0);
        wr(6'h18, 32'h10);
        check("R11 tc enabled", irq, 1);
        rd(6'h18, v); check("R11 ie readback", v, 32'h10);
        wr(6'h1C, 32'h10);
        check("R11 cleared", irq, 0);
        wr(6'h18, 32'h02);
        check("R11 rx req below thr", irq, 0);
        wr(6'h20, 32'h0002);
        check("R11 rx req at thr", irq, 1);
        wr(6'h18, 0);

        // R7 transmit room
        wr(6'h20, 32'h1202);
        for (int i = 0; i < 3; i++) wr(6'h24, 32'h300 + i);
        rd(6'h1C, v); check("R7 above tx thr", v[2], 0);
        tx_pull();
        rd(6'h1C, v); check("R7 at tx thr", v[2], 1);

        // R12 unmapped
        rd(6'h30, v); check("R12 unmapped", v, 0);
        rd(6'h04, v); check("R12 unmapped 04", v, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule